// File: doc/BRIEF.md
# Shared-Bus Multi-Cycle Datapath

This block is the data side of a multi-cycle processor in which every register and functional unit trades values over one common 16-bit bus. A program counter, an instruction register, an eight-entry register file with a single port, a memory address register, a memory data register, an ALU with a Y operand register and a Z result register, and a three-bit flags register all hang off that bus. A unit takes the bus value at the clock edge when its write strobe is high. It places its value on the bus only while its read enable is high. Because only one unit can drive the bus at a time, each cycle moves a single value from one unit to another.

An external sequencer owns every strobe. A typical fetch puts the PC on the bus, loads it into the memory address register, and forms PC+1 in Z, with the constant 1 standing in for Y. The next cycle moves Z back into the PC while the memory data register waits for memory. The bus drivers are modelled as a one-hot select. When no unit drives, the bus reads zero. When two or more drive at once, the bus also reads zero and a conflict output is raised.

Top module: `shared_bus_datapath`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero: PC, IR, register file, Y, Z, MAR, MDR and flags.
- R2: With exactly one of pc_rd, rf_rd, mdr_rd, z_rd high, the bus carries that unit's current value in the same cycle.
- R3: With none of the four read enables high, the bus reads zero.
- R4: With two or more read enables high, bus_conflict is 1 and the bus reads zero. Otherwise bus_conflict is 0.
- R5: The PC loads the bus at the clock edge when pc_wr is high and holds its value otherwise.
- R6: The register file has one port whose address is IR[11:9] when rf_sel is 0 and IR[8:6] when rf_sel is 1. rf_rd drives the addressed entry onto the bus, and rf_wr writes the bus into that entry.
- R7: The ALU's first operand is the bus. Its second operand is Y when alu_src2 is 1 and the constant 1 when alu_src2 is 0. Y loads the bus when y_wr is high.
- R8: On z_wr, Z captures the ALU result, where alu_op 00 is add, 01 is subtract (first minus second), 10 is bitwise AND and 11 is bitwise OR. z_rd places Z on the bus.
- R9: MAR loads the bus on mar_wr and holds otherwise. mem_addr always shows MAR.
- R10: MDR loads mem_rdata when mdr_ld_mem is high and mem_wait is low, which takes priority over the bus. Otherwise it loads the bus when mdr_wr is high, and it holds in every other case. mem_wdata always shows MDR.
- R11: The flags update only at an edge where z_wr is high, alu_op is 00 and alu_src2 is 1. Bit 0 is set when the sum is zero, bit 1 copies the sum's bit 15, and bit 2 is the carry out of the 16-bit add.
- R12: IR loads the bus on ir_wr and holds otherwise. ir_q shows IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_rd | input | 1 | PC drives the bus |
| pc_wr | input | 1 | PC loads the bus |
| ir_wr | input | 1 | IR loads the bus |
| rf_rd | input | 1 | Register file drives the bus |
| rf_wr | input | 1 | Register file writes the bus |
| rf_sel | input | 1 | Register address select: 0 picks IR[11:9], 1 picks IR[8:6] |
| y_wr | input | 1 | Y loads the bus |
| alu_src2 | input | 1 | Second ALU operand: 1 is Y, 0 is constant 1 |
| alu_op | input | 2 | 00 add, 01 subtract, 10 AND, 11 OR |
| z_rd | input | 1 | Z drives the bus |
| z_wr | input | 1 | Z captures the ALU result |
| mar_wr | input | 1 | MAR loads the bus |
| mdr_rd | input | 1 | MDR drives the bus |
| mdr_wr | input | 1 | MDR loads the bus |
| mdr_ld_mem | input | 1 | MDR loads memory data when mem_wait is low |
| mem_wait | input | 1 | Memory not yet ready |
| mem_rdata | input | 16 | Memory read data |
| mem_addr | output | 16 | Current MAR |
| mem_wdata | output | 16 | Current MDR |
| ir_q | output | 16 | Current IR |
| flags | output | 3 | {carry, negative, zero} |
| bus | output | 16 | Common bus value |
| bus_conflict | output | 1 | More than one unit drives the bus |

## Verification
The cycle that sends PC+1 from Z back to the PC can also be the cycle in which MDR waits on memory. The bench provokes this by raising z_rd, pc_wr and mdr_ld_mem together with mem_wait held high. In that cycle the bus must show the incremented value and mem_wdata must keep its earlier contents. The next cycle must then show the new PC value on the bus. A second overlap applies mdr_ld_mem and mdr_wr in the same cycle, and only the memory data may land in MDR.

// File: rtl/shared_bus_datapath.sv
module shared_bus_datapath #(
  parameter int W    = 16,
  parameter int NREG = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pc_rd,
  input  logic         pc_wr,
  input  logic         ir_wr,
  input  logic         rf_rd,
  input  logic         rf_wr,
  input  logic         rf_sel,
  input  logic         y_wr,
  input  logic         alu_src2,
  input  logic [1:0]   alu_op,
  input  logic         z_rd,
  input  logic         z_wr,
  input  logic         mar_wr,
  input  logic         mdr_rd,
  input  logic         mdr_wr,
  input  logic         mdr_ld_mem,
  input  logic         mem_wait,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic [W-1:0] ir_q,
  output logic [2:0]   flags,
  output logic [W-1:0] bus,
  output logic         bus_conflict
);
  localparam int AW    = $clog2(NREG);
  localparam int F1_HI = W - 5;
  localparam int F2_HI = F1_HI - AW;
  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_SUB = 2'b01;
  localparam logic [1:0] OP_AND = 2'b10;

  logic [W-1:0] pc_q, y_q, z_q, mar_q, mdr_q, ir_r;
  logic [W-1:0] rf [NREG];
  logic [AW-1:0] rf_addr;
  logic [W-1:0] rf_out, alu_b, alu_res;
  logic [W:0]   sum;
  logic [3:0]   drv;
  logic         multi, flag_upd;

  assign drv          = {z_rd, mdr_rd, rf_rd, pc_rd};
  assign multi        = (drv & (drv - 4'd1)) != 4'd0;
  assign bus_conflict = multi;

  assign rf_addr = rf_sel ? ir_r[F2_HI -: AW] : ir_r[F1_HI -: AW];
  assign rf_out  = rf[rf_addr];

  always_comb begin
    bus = '0;
    if (!multi) begin
      if (pc_rd)  bus = pc_q;
      if (rf_rd)  bus = rf_out;
      if (mdr_rd) bus = mdr_q;
      if (z_rd)   bus = z_q;
    end
  end

  assign alu_b = alu_src2 ? y_q : W'(1);
  assign sum   = {1'b0, bus} + {1'b0, alu_b};

  always_comb begin
    case (alu_op)
      OP_ADD:  alu_res = sum[W-1:0];
      OP_SUB:  alu_res = bus - alu_b;
      OP_AND:  alu_res = bus & alu_b;
      default: alu_res = bus | alu_b;
    endcase
  end

  assign flag_upd = z_wr && (alu_op == OP_ADD) && alu_src2;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_r  <= '0;
      y_q   <= '0;
      z_q   <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      flags <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (pc_wr)  pc_q  <= bus;
      if (ir_wr)  ir_r  <= bus;
      if (y_wr)   y_q   <= bus;
      if (z_wr)   z_q   <= alu_res;
      if (mar_wr) mar_q <= bus;
      if (rf_wr)  rf[rf_addr] <= bus;
      if (mdr_ld_mem && !mem_wait) mdr_q <= mem_rdata;
      else if (mdr_wr)             mdr_q <= bus;
      if (flag_upd) flags <= {sum[W], sum[W-1], sum[W-1:0] == '0};
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign ir_q      = ir_r;

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (drv == 4'd0) |-> (bus == '0)); // R3
  AST_CONFLICT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    ($countones(drv) > 1) |-> (bus_conflict && bus == '0)); // R4
  AST_SINGLE_NO_CONFLICT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv) |-> !bus_conflict); // R4
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pc_wr |=> $stable(pc_q)); // R5
  AST_MAR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mar_wr |=> $stable(mem_addr)); // R9
  AST_MDR_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mdr_ld_mem && mem_wait && !mdr_wr) |=> $stable(mem_wdata)); // R10
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(z_wr && alu_op == 2'b00 && alu_src2) |=> $stable(flags)); // R11
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ir_wr |=> $stable(ir_q)); // R12
endmodule

// File: tb/shared_bus_datapath_bench.sv
module shared_bus_datapath_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic pc_rd, pc_wr, ir_wr, rf_rd, rf_wr, rf_sel, y_wr, alu_src2;
  logic [1:0] alu_op;
  logic z_rd, z_wr, mar_wr, mdr_rd, mdr_wr, mdr_ld_mem, mem_wait;
  logic [15:0] mem_rdata, mem_addr, mem_wdata, ir_q, bus;
  logic [2:0] flags;
  logic bus_conflict;

  always #2 clk = ~clk;

  shared_bus_datapath u_shared_bus_datapath (
    .clk(clk), .rst(rst), .pc_rd(pc_rd), .pc_wr(pc_wr), .ir_wr(ir_wr),
    .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_sel(rf_sel), .y_wr(y_wr),
    .alu_src2(alu_src2), .alu_op(alu_op), .z_rd(z_rd), .z_wr(z_wr),
    .mar_wr(mar_wr), .mdr_rd(mdr_rd), .mdr_wr(mdr_wr),
    .mdr_ld_mem(mdr_ld_mem), .mem_wait(mem_wait), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ir_q(ir_q),
    .flags(flags), .bus(bus), .bus_conflict(bus_conflict));

  localparam int S_BUS = 0, S_CONF = 1, S_FLAGS = 2, S_ADDR = 3, S_WDATA = 4, S_IR = 5;

  typedef struct {
    int          cyc;
    int          sig;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int ncyc = 0, checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [15:0] observe(int s);
    case (s)
      S_BUS:   return bus;
      S_CONF:  return {15'd0, bus_conflict};
      S_FLAGS: return {13'd0, flags};
      S_ADDR:  return mem_addr;
      S_WDATA: return mem_wdata;
      default: return ir_q;
    endcase
  endfunction

  always @(negedge clk) begin
    ncyc <= ncyc + 1;
    while (q.size() > 0 && q[0].cyc == ncyc + 1) begin
      item_t it;
      logic [15:0] act;
      it  = q.pop_front();
      act = observe(it.sig);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s signal=%0d actual=%h expected=%h", it.req, it.sig, act, it.exp);
      end
    end
  end

  task automatic want(int s, logic [15:0] v, string r);
    q.push_back('{ncyc + 1, s, v, r});
  endtask

  task automatic clr();
    {pc_rd, pc_wr, ir_wr, rf_rd, rf_wr, rf_sel, y_wr, alu_src2} = '0;
    alu_op = 2'b00;
    {z_rd, z_wr, mar_wr, mdr_rd, mdr_wr, mdr_ld_mem, mem_wait} = '0;
    mem_rdata = '0;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
    clr();
  endtask

  task automatic mem_load(logic [15:0] v);
    mdr_ld_mem = 1; mem_rdata = v;
    want(S_WDATA, v, "R10");
    step();
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    #1; rst = 0;
    want(S_BUS, 16'h0, "R3"); want(S_CONF, 16'h0, "R4");
    want(S_FLAGS, 16'h0, "R1"); want(S_ADDR, 16'h0, "R1");
    want(S_IR, 16'h0, "R1"); want(S_WDATA, 16'h0, "R1");
    step();
    pc_rd = 1; want(S_BUS, 16'h0, "R1"); step();
    mdr_ld_mem = 1; mem_wait = 1; mem_rdata = 16'h1234;
    want(S_WDATA, 16'h0, "R10"); step();
    mem_load(16'h1234);
    mdr_ld_mem = 1; mem_rdata = 16'h5555; mdr_wr = 1; z_rd = 1;
    want(S_WDATA, 16'h5555, "R10"); step();
    mdr_wr = 1; pc_rd = 1; want(S_WDATA, 16'h0, "R10"); step();
    mem_load(16'h1540);
    mdr_rd = 1; ir_wr = 1;
    want(S_BUS, 16'h1540, "R2"); want(S_IR, 16'h1540, "R12"); step();
    pc_rd = 1; want(S_IR, 16'h1540, "R12"); step();
    mem_load(16'h8000);
    mdr_rd = 1; rf_wr = 1; rf_sel = 0; step();
    mem_load(16'h8001);
    mdr_rd = 1; rf_wr = 1; rf_sel = 1; step();
    rf_rd = 1; rf_sel = 1; y_wr = 1; want(S_BUS, 16'h8001, "R6"); step();
    rf_rd = 1; rf_sel = 0; alu_src2 = 1; z_wr = 1;
    want(S_BUS, 16'h8000, "R6"); want(S_FLAGS, 16'h0004, "R11"); step();
    z_rd = 1; rf_wr = 1; rf_sel = 0; want(S_BUS, 16'h0001, "R7"); step();
    rf_rd = 1; rf_sel = 0; want(S_BUS, 16'h0001, "R6"); step();
    rf_rd = 1; rf_sel = 1; want(S_BUS, 16'h8001, "R6"); step();
    // fetch-style increment
    pc_rd = 1; mar_wr = 1; alu_src2 = 0; z_wr = 1;
    want(S_BUS, 16'h0, "R5"); want(S_FLAGS, 16'h0004, "R11"); want(S_ADDR, 16'h0, "R9");
    step();
    z_rd = 1; pc_wr = 1; mdr_ld_mem = 1; mem_wait = 1; mem_rdata = 16'h7777;
    want(S_BUS, 16'h0001, "R7"); want(S_WDATA, 16'h8001, "R10"); step();
    pc_rd = 1; mar_wr = 1; want(S_BUS, 16'h0001, "R5"); want(S_ADDR, 16'h0001, "R9"); step();
    pc_rd = 1; want(S_BUS, 16'h0001, "R5"); want(S_ADDR, 16'h0001, "R9"); step();
    // other ALU operations, Y = 8001, reg(R1 field) = 0001
    rf_rd = 1; alu_src2 = 1; alu_op = 2'b01; z_wr = 1;
    want(S_FLAGS, 16'h0004, "R11"); step();
    z_rd = 1; want(S_BUS, 16'h8000, "R8"); step();
    rf_rd = 1; alu_src2 = 1; alu_op = 2'b10; z_wr = 1; step();
    z_rd = 1; want(S_BUS, 16'h0001, "R8"); step();
    rf_rd = 1; alu_src2 = 1; alu_op = 2'b11; z_wr = 1; step();
    z_rd = 1; want(S_BUS, 16'h8001, "R8"); step();
    // flag corners
    mem_load(16'hFFFF);
    mdr_rd = 1; y_wr = 1; step();
    mem_load(16'h0001);
    mdr_rd = 1; alu_src2 = 1; z_wr = 1; want(S_FLAGS, 16'h0005, "R11"); step();
    z_rd = 1; want(S_BUS, 16'h0000, "R8"); step();
    alu_src2 = 1; z_wr = 1; want(S_FLAGS, 16'h0002, "R11"); step();
    z_rd = 1; want(S_BUS, 16'hFFFF, "R8"); step();
    mdr_rd = 1; alu_src2 = 1; want(S_FLAGS, 16'h0002, "R11"); step();
    // conflict
    pc_rd = 1; z_rd = 1; want(S_BUS, 16'h0, "R4"); want(S_CONF, 16'h1, "R4"); step();
    mdr_rd = 1; want(S_CONF, 16'h0, "R4"); want(S_BUS, 16'h0001, "R2"); step();
    step(); step();
    if (q.size() != 0) begin
      fails++; checks++;
      $display("FAIL scoreboard R1 actual=%0d pending expected=0", q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule